// File: doc/BRIEF.md
# Accumulator Processor with Register-Move Instructions

This block is a small 8-bit accumulator processor with 64 bytes of internal memory. Each instruction is one byte. The top bits of that byte select the operation and the low six bits give an address. A step counter walks through a three-step fetch and then one or two execute steps. A decoder combines the current step with the latched opcode to choose which register loads and which single source drives the internal data bus.

The base operations are add, AND, jump and increment. Two data-movement instructions are added to them: one copies the accumulator into a general register R, and the other copies R back into the accumulator. To fit these, the opcode register is four bits wide. The two moves use codes 1110 and 1111, and the older operations still decode from the upper two opcode bits only.

Memory is filled through a load port, normally while reset is held. Reset releases the processor to run from address 0. The accumulator, R, the program counter and an end-of-instruction pulse are brought out so a system can observe them.

Top module: `accum_cpu`

## Requirements
- R1: While reset is asserted, acc_o, rreg_o and pc_o read 0 and instr_done is low. The first fetch after reset reads address 0.
- R2: A fetch reads the byte at pc_o and then increments pc_o by one, wrapping modulo 64. The opcode is byte bits 7:4 and the address field is bits 5:0.
- R3: An opcode with bits 3:2 = 00 adds the memory byte at the address field to the accumulator, modulo 256.
- R4: An opcode with bits 3:2 = 01 replaces the accumulator with its bitwise AND with the memory byte at the address field.
- R5: An opcode with bits 3:2 = 10 loads pc_o with the address field.
- R6: Opcodes 1100 and 1101 add one to the accumulator, modulo 256. The address field has no effect on the result.
- R7: Opcode 1110 copies the accumulator into R and leaves the accumulator unchanged. For example, byte E0 gives opcode 1110 with address field 20.
- R8: Opcode 1111 copies R into the accumulator and leaves R unchanged. For example, byte F0 gives opcode 1111 with address field 30.
- R9: Add and AND take 5 clock cycles from the start of fetch. Every other instruction takes 4. instr_done is high for exactly the last cycle of each instruction, and no more than one source drives the internal bus in any cycle.
- R10: A cycle with load_en high writes load_data into memory at load_addr. The processor later reads that value as an operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Memory preload write strobe |
| load_addr | input | 6 | Preload write address |
| load_data | input | 8 | Preload write data |
| acc_o | output | 8 | Accumulator value |
| rreg_o | output | 8 | General register R value |
| pc_o | output | 6 | Program counter value |
| instr_done | output | 1 | High in the final cycle of each instruction |

## Verification
The assertions assume two things: memory is only preloaded while reset is held, and reset is released only at a cycle boundary. Under those conditions every instruction runs to completion without its operand bytes changing underneath it. The stimulus follows both rules. Each program, whether random or directed, is written in full with rst_n low, and rst_n is released on a falling clock edge. The random programs are built from a fixed seed and weighted toward the two move opcodes and away from jumps, so most runs pass through long stretches of straight-line code. The directed programs cover accumulator wrap on increment and an AC-to-R-to-AC round trip.

// File: rtl/accum_cpu_pkg.sv
package accum_cpu_pkg;

   // internal bus source indices
   localparam int SRC_MEM = 0;
   localparam int SRC_PC  = 1;
   localparam int SRC_DR  = 2;
   localparam int SRC_AC  = 3;
   localparam int SRC_R   = 4;
   localparam int NUM_SRC = 5;

   typedef enum logic [2:0] {
      S_FA, S_FB, S_FC, S_X1, S_X2
   } step_e;

   typedef enum logic [3:0] {
      U_FA, U_FB, U_FC,
      U_ADD1, U_ADD2, U_AND1, U_AND2,
      U_JMP, U_INC, U_TO_R, U_FROM_R, U_NONE
   } uop_e;

   typedef enum logic [1:0] {
      ALU_PASS, ALU_ADD, ALU_AND
   } alu_e;

   typedef struct packed {
      logic [NUM_SRC-1:0] bus_en;
      logic               ar_ld;
      logic               pc_ld;
      logic               pc_inc;
      logic               dr_ld;
      logic               ir_ld;
      logic               ac_ld;
      logic               ac_inc;
      logic               r_ld;
      alu_e               alu;
   } ctrl_t;

endpackage

// File: rtl/accum_cpu_mem.sv
module accum_cpu_mem #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   assign rd_data = store[rd_addr];

endmodule

// File: rtl/accum_cpu_seq.sv
module accum_cpu_seq
   import accum_cpu_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  more_steps,
   input  logic  done,
   output step_e step_q
);
   step_e step_d;

   always_comb begin
      unique case (step_q)
         S_FA:    step_d = S_FB;
         S_FB:    step_d = S_FC;
         S_FC:    step_d = S_X1;
         S_X1:    step_d = more_steps ? S_X2 : S_FA;
         default: step_d = S_FA;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= S_FA;
      else        step_q <= step_d;
   end

   p_fetch_a_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == S_FA) |=> (step_q == S_FB));
   p_fetch_b_c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == S_FB) |=> (step_q == S_FC));
   p_fetch_to_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == S_FC) |=> (step_q == S_X1));
   p_done_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (step_q == S_FA));

endmodule

// File: rtl/accum_cpu_decode.sv
module accum_cpu_decode
   import accum_cpu_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  step_e             step,
   input  logic [OPC_W-1:0]  ir,
   output uop_e              uop,
   output ctrl_t             ctrl,
   output logic              more_steps,
   output logic              done
);
   // combine step and opcode into one micro-operation
   always_comb begin
      uop = U_NONE;
      unique case (step)
         S_FA: uop = U_FA;
         S_FB: uop = U_FB;
         S_FC: uop = U_FC;
         S_X1: begin
            casez (ir)
               4'b00??: uop = U_ADD1;
               4'b01??: uop = U_AND1;
               4'b10??: uop = U_JMP;
               4'b110?: uop = U_INC;
               4'b1110: uop = U_TO_R;
               default: uop = U_FROM_R;
            endcase
         end
         S_X2:    uop = ir[2] ? U_AND2 : U_ADD2;
         default: uop = U_NONE;
      endcase
   end

   always_comb begin
      ctrl = '0;
      unique case (uop)
         U_FA: begin
            ctrl.bus_en[SRC_PC] = 1'b1;
            ctrl.ar_ld          = 1'b1;
         end
         U_FB: begin
            ctrl.bus_en[SRC_MEM] = 1'b1;
            ctrl.dr_ld           = 1'b1;
            ctrl.pc_inc          = 1'b1;
         end
         U_FC: begin
            ctrl.bus_en[SRC_DR] = 1'b1;
            ctrl.ir_ld          = 1'b1;
            ctrl.ar_ld          = 1'b1;
         end
         U_ADD1, U_AND1: begin
            ctrl.bus_en[SRC_MEM] = 1'b1;
            ctrl.dr_ld           = 1'b1;
         end
         U_ADD2: begin
            ctrl.bus_en[SRC_DR] = 1'b1;
            ctrl.ac_ld          = 1'b1;
            ctrl.alu            = ALU_ADD;
         end
         U_AND2: begin
            ctrl.bus_en[SRC_DR] = 1'b1;
            ctrl.ac_ld          = 1'b1;
            ctrl.alu            = ALU_AND;
         end
         U_JMP: begin
            ctrl.bus_en[SRC_DR] = 1'b1;
            ctrl.pc_ld          = 1'b1;
         end
         U_INC:  ctrl.ac_inc = 1'b1;
         U_TO_R: begin
            ctrl.bus_en[SRC_AC] = 1'b1;
            ctrl.r_ld           = 1'b1;
         end
         U_FROM_R: begin
            ctrl.bus_en[SRC_R] = 1'b1;
            ctrl.ac_ld         = 1'b1;
            ctrl.alu           = ALU_PASS;
         end
         default: ctrl = '0;
      endcase
   end

   assign more_steps = (uop == U_ADD1) || (uop == U_AND1);
   assign done = (uop == U_ADD2) || (uop == U_AND2) || (uop == U_JMP) ||
                 (uop == U_INC)  || (uop == U_TO_R) || (uop == U_FROM_R);

endmodule

// File: rtl/accum_cpu_datapath.sv
module accum_cpu_datapath
   import accum_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   parameter int OPC_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctrl_t             ctrl,
   input  logic [DATA_W-1:0] mem_rd,
   output logic [ADDR_W-1:0] ar_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [OPC_W-1:0]  ir_o,
   output logic [DATA_W-1:0] ac_o,
   output logic [DATA_W-1:0] r_o
);
   localparam int OPC_LSB = DATA_W - OPC_W;
   localparam int PC_PAD  = DATA_W - ADDR_W;

   logic [DATA_W-1:0] dr_q;
   logic [DATA_W-1:0] src    [NUM_SRC];
   logic [DATA_W-1:0] masked [NUM_SRC];
   logic [DATA_W-1:0] bus;

   assign src[SRC_MEM] = mem_rd;
   assign src[SRC_PC]  = {{PC_PAD{1'b0}}, pc_o};
   assign src[SRC_DR]  = dr_q;
   assign src[SRC_AC]  = ac_o;
   assign src[SRC_R]   = r_o;

   // each source is gated by its enable, like a tri-state driver
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_drv
      assign masked[g] = src[g] & {DATA_W{ctrl.bus_en[g]}};
   end

   always_comb begin
      bus = '0;
      for (int i = 0; i < NUM_SRC; i++) bus = bus | masked[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ar_o <= '0;
         pc_o <= '0;
         dr_q <= '0;
         ir_o <= '0;
         ac_o <= '0;
         r_o  <= '0;
      end else begin
         if (ctrl.ar_ld)       ar_o <= bus[ADDR_W-1:0];
         if (ctrl.pc_ld)       pc_o <= bus[ADDR_W-1:0];
         else if (ctrl.pc_inc) pc_o <= pc_o + 1'b1;
         if (ctrl.dr_ld)       dr_q <= bus;
         if (ctrl.ir_ld)       ir_o <= bus[DATA_W-1:OPC_LSB];
         if (ctrl.r_ld)        r_o  <= bus;
         if (ctrl.ac_ld) begin
            unique case (ctrl.alu)
               ALU_ADD: ac_o <= ac_o + bus;
               ALU_AND: ac_o <= ac_o & bus;
               default: ac_o <= bus;
            endcase
         end else if (ctrl.ac_inc) begin
            ac_o <= ac_o + 1'b1;
         end
      end
   end

   p_bus_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctrl.bus_en));
   p_r_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.r_ld |=> (r_o == $past(r_o)));

endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
   import accum_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   parameter int OPC_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] rreg_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic              instr_done
);
   if (OPC_W != 4) begin : g_bad_opc
      $error("accum_cpu: opcode decode needs OPC_W == 4");
   end
   if (ADDR_W > DATA_W - 2) begin : g_bad_addr
      $error("accum_cpu: address field overlaps the two base opcode bits");
   end

   step_e             step_q;
   uop_e              uop;
   ctrl_t             ctrl;
   logic              more_steps;
   logic [OPC_W-1:0]  ir_q;
   logic [ADDR_W-1:0] ar_q;
   logic [DATA_W-1:0] mem_rd;

   accum_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk     (clk),
      .wr_en   (load_en),
      .wr_addr (load_addr),
      .wr_data (load_data),
      .rd_addr (ar_q),
      .rd_data (mem_rd)
   );

   accum_cpu_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .more_steps (more_steps),
      .done       (instr_done),
      .step_q     (step_q)
   );

   accum_cpu_decode #(.OPC_W(OPC_W)) u_dec (
      .step       (step_q),
      .ir         (ir_q),
      .uop        (uop),
      .ctrl       (ctrl),
      .more_steps (more_steps),
      .done       (instr_done)
   );

   accum_cpu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_dp (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl   (ctrl),
      .mem_rd (mem_rd),
      .ar_o   (ar_q),
      .pc_o   (pc_o),
      .ir_o   (ir_q),
      .ac_o   (acc_o),
      .r_o    (rreg_o)
   );

   p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == S_FB) |=> (pc_o == $past(pc_o) + 1'b1));
   p_jump_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (uop == U_JMP) |=> (pc_o == $past(ar_q)));
   p_inc_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (uop == U_INC) |=> (acc_o == $past(acc_o) + 1'b1));
   p_copy_to_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (uop == U_TO_R) |=> (rreg_o == $past(acc_o) && acc_o == $past(acc_o)));
   p_copy_from_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (uop == U_FROM_R) |=> (acc_o == $past(rreg_o) && rreg_o == $past(rreg_o)));

endmodule

// File: tb/accum_cpu_bench.sv
`timescale 1ns/1ps
module accum_cpu_bench;
   localparam int DW = 8;
   localparam int AW = 6;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_en = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [DW-1:0] load_data = '0;
   logic [DW-1:0] acc_o;
   logic [DW-1:0] rreg_o;
   logic [AW-1:0] pc_o;
   logic          instr_done;

   int vectors = 0;
   int miscompares = 0;

   logic [DW-1:0] m_mem [DEPTH];
   logic [DW-1:0] m_ac;
   logic [DW-1:0] m_r;
   logic [AW-1:0] m_pc;

   always #4 clk = ~clk;

   accum_cpu u_accum_cpu (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en    (load_en),
      .load_addr  (load_addr),
      .load_data  (load_data),
      .acc_o      (acc_o),
      .rreg_o     (rreg_o),
      .pc_o       (pc_o),
      .instr_done (instr_done)
   );

   function automatic int exec_cycles(logic [7:0] b);
      return (b[7:6] == 2'b00 || b[7:6] == 2'b01) ? 5 : 4;
   endfunction

   function automatic string op_tag(logic [7:0] b);
      casez (b[7:4])
         4'b00??: return "R3";
         4'b01??: return "R4";
         4'b10??: return "R5";
         4'b110?: return "R6";
         4'b1110: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string tag, int actual, int expected);
      vectors++;
      if (actual != expected) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
      end
   endtask

   task automatic step_model(output logic [7:0] b);
      b = m_mem[m_pc];
      m_pc = m_pc + 1'b1;
      casez (b[7:4])
         4'b00??: m_ac = m_ac + m_mem[b[5:0]];
         4'b01??: m_ac = m_ac & m_mem[b[5:0]];
         4'b10??: m_pc = b[5:0];
         4'b110?: m_ac = m_ac + 1'b1;
         4'b1110: m_r  = m_ac;
         default: m_ac = m_r;
      endcase
   endtask

   task automatic run_prog(int n_instr);
      int cnt;
      int retired;
      logic [7:0] b;
      rst_n = 1'b0;
      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk);
         load_en = 1'b1;
         load_addr = AW'(a);
         load_data = m_mem[a];
      end
      @(negedge clk);
      load_en = 1'b0;
      check("R1 acc in reset", acc_o, 0);
      check("R1 rreg in reset", rreg_o, 0);
      check("R1 pc in reset", pc_o, 0);
      check("R1 done in reset", instr_done, 0);
      @(negedge clk);
      rst_n = 1'b1;
      m_pc = '0; m_ac = '0; m_r = '0;
      cnt = 1;
      retired = 0;
      while (retired < n_instr) begin
         @(negedge clk);
         cnt++;
         if (instr_done) begin
            step_model(b);
            check($sformatf("R9 cycles op %02h", b), cnt, exec_cycles(b));
            cnt = 0;
            @(posedge clk);
            #1;
            check($sformatf("%s acc op %02h", op_tag(b), b), acc_o, m_ac);
            check($sformatf("%s rreg op %02h", op_tag(b), b), rreg_o, m_r);
            check($sformatf("%s pc op %02h", (b[7:6] == 2'b10) ? "R5" : "R2", b),
                  pc_o, m_pc);
            retired++;
         end else if (cnt > 6) begin
            check("R9 instruction never completed", cnt, 5);
            retired = n_instr;
         end
      end
   endtask

   function automatic logic [7:0] rand_byte();
      int k = $urandom_range(0, 9);
      logic [5:0] f = 6'($urandom_range(0, 63));
      case (k)
         0, 1:    return {2'b00, f};
         2, 3:    return {2'b01, f};
         4:       return {2'b10, f};
         5, 6:    return {3'b110, f[4:0]};
         7:       return {4'b1110, f[3:0]};
         default: return {4'b1111, f[3:0]};
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      void'($urandom(32'd5171));

      // directed: add preloaded byte, copy to R, bump AC, copy back (R7 R8 R10)
      for (int a = 0; a < DEPTH; a++) m_mem[a] = 8'hC0;
      m_mem[0]  = 8'h3F;
      m_mem[1]  = 8'hE0;
      m_mem[2]  = 8'hC5;
      m_mem[3]  = 8'hF0;
      m_mem[4]  = 8'h84;
      m_mem[63] = 8'h25;
      run_prog(5);
      check("R10 preloaded operand reached acc", acc_o, 8'h25);
      check("R7 rreg holds copied acc", rreg_o, 8'h25);
      check("R5 jump to self", pc_o, 4);

      // directed: increment wraps accumulator (R6)
      for (int a = 0; a < DEPTH; a++) m_mem[a] = 8'hC0;
      m_mem[0]  = 8'h3F;
      m_mem[1]  = 8'hC0;
      m_mem[2]  = 8'hE0;
      m_mem[3]  = 8'h83;
      m_mem[63] = 8'hFF;
      run_prog(4);
      check("R6 inc wraps to zero", acc_o, 0);
      check("R7 rreg after copy of zero", rreg_o, 0);

      // directed: AND with preloaded mask (R4)
      for (int a = 0; a < DEPTH; a++) m_mem[a] = 8'hC0;
      m_mem[0]  = 8'h3E;
      m_mem[1]  = 8'h7F;
      m_mem[62] = 8'hB6;
      m_mem[63] = 8'h3C;
      run_prog(2);
      check("R4 and with mask", acc_o, 8'h34);

      // constrained random programs
      for (int p = 0; p < 8; p++) begin
         for (int a = 0; a < DEPTH; a++) m_mem[a] = rand_byte();
         run_prog(150);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule